// File: doc/BRIEF.md
# OTG Session Request Detector

This block sits on the A-device side of a dual-role USB port and watches the bus for a session request from an attached B-device. A B-device asks for a session in one of two ways: it briefly pulls a data line high, or it briefly drives VBUS. Software chooses which of these the detector listens for, and it can switch detection off altogether. One case for switching it off is a low battery, where the A-device should not be made to power the bus.

The raw DP, DM and VBUS-valid levels come from the analog front end. Each one passes through a two-flop synchronizer. A millisecond tick sets the time base. In data-line mode, a high level on either DP (a full-speed requester) or DM (a low-speed requester) counts once it has stayed high for a minimum number of ticks. In VBUS mode, a rising edge of VBUS-valid counts if it happens while the A-device is not driving the bus itself, and VBUS then stays valid for a minimum number of ticks. An accepted request sets a sticky flag. Software clears the flag with a one-cycle write-one pulse. Changing the mode or the enable flushes any width measurement that is in progress.

Top module: `otg_sreq_detect`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset, `reqDetected` is 0.
- R2: In data-line mode (`detEnable`=1, `detSelLine`=1), suppose DP or DM stays high across LINE_MIN_TICKS `msTick` pulses (default 5). `reqDetected` then goes to 1 on the clock edge that follows the qualifying tick.
- R3: A data-line high level that ends before LINE_MIN_TICKS ticks have been counted leaves `reqDetected` unchanged.
- R4: `detSelLine`=1 selects data-line detection and `detSelLine`=0 selects VBUS detection. Activity of the mechanism that is not selected has no effect on `reqDetected`.
- R5: In VBUS mode, suppose VBUS-valid rises while `aDrivesVbus`=0 and then stays valid for VBUS_MIN_TICKS ticks (default 1). The flag then sets. A rise while `aDrivesVbus`=1 is ignored.
- R6: While `detEnable`=0, `reqDetected` never rises, whatever the select bit and the line levels are.
- R7: `reqDetected` stays 1 until `clearReq`=1 is sampled. If a clear and a new detection fall in the same cycle, the flag ends up 1.
- R8: When `detEnable` or `detSelLine` differs from its value in the previous cycle, both width counters restart from zero, so the width measured before the change does not count.
- R9: Each raw line input is seen by the detection logic two clock cycles after it changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msTick | input | 1 | One-cycle pulse every millisecond |
| detEnable | input | 1 | 1 enables request detection |
| detSelLine | input | 1 | 1 selects data-line detection, 0 selects VBUS detection |
| aDrivesVbus | input | 1 | 1 while the A-device supplies VBUS |
| dpRaw | input | 1 | Asynchronous DP level |
| dmRaw | input | 1 | Asynchronous DM level |
| vbusRaw | input | 1 | Asynchronous VBUS-above-threshold level |
| clearReq | input | 1 | Write-one pulse that clears the flag |
| reqDetected | output | 1 | Sticky session-request flag |

## Verification
The checker module verifies a set of properties on every cycle:
- the flag holds unless a clear is sampled;
- the flag never rises while detection is disabled;
- a change of mode or enable leaves both counters at zero;
- the line counter never passes its limit;
- the flag is clear after reset.

Some behaviour can only be shown by the bench's scenarios, where the reference model follows the flag cycle by cycle:
- a pulse that is one tick too short is rejected;
- DM counts as well as DP;
- the mechanism that is not selected has no effect;
- a VBUS rise that the A-device caused itself is ignored;
- a width measurement is restarted by a mode change;
- set wins over clear;
- the two-cycle synchronizer latency is correct.

// File: rtl/srqd_pkg.sv
package srqd_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic lineCount;
    logic lineFlush;
    logic vbusCount;
    logic vbusFlush;
    logic setFlag;
    logic clearFlag;
  } srqd_strobe_t;

  // Status from datapath to control.
  typedef struct packed {
    logic lineHigh;
    logic lineAtLast;
    logic vbusHigh;
    logic vbusRise;
    logic vbusAtLast;
  } srqd_status_t;

endpackage

// File: rtl/srqd_dpath.sv
module srqd_dpath
  import srqd_pkg::*;
#(
  parameter int LINE_MIN_TICKS = 5,
  parameter int VBUS_MIN_TICKS = 1,
  parameter int SYNC_DEPTH     = 2,
  parameter int CNT_W          = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dpRaw,
  input  logic             dmRaw,
  input  logic             vbusRaw,
  input  srqd_strobe_t     strobe,
  output srqd_status_t     status,
  output logic [CNT_W-1:0] lineCnt,
  output logic [CNT_W-1:0] vbusCnt,
  output logic             reqDetected
);

  localparam int NUM_IN = 3;
  localparam logic [CNT_W-1:0] LINE_LAST = CNT_W'(LINE_MIN_TICKS - 1);
  localparam logic [CNT_W-1:0] LINE_TOP  = CNT_W'(LINE_MIN_TICKS);
  localparam logic [CNT_W-1:0] VBUS_LAST = CNT_W'(VBUS_MIN_TICKS - 1);
  localparam logic [CNT_W-1:0] VBUS_TOP  = CNT_W'(VBUS_MIN_TICKS);

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] syncOut;
  logic              vbusPrev;

  assign rawIn = {vbusRaw, dmRaw, dpRaw};

  // One synchronizer chain per input.
  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_sync
    logic [SYNC_DEPTH-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_DEPTH-2:0], rawIn[gi]};
    end
    assign syncOut[gi] = chain[SYNC_DEPTH-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vbusPrev <= 1'b0;
    else       vbusPrev <= syncOut[2];
  end

  // Line-high width counter, saturating at its limit.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                    lineCnt <= '0;
    else if (strobe.lineFlush)                    lineCnt <= '0;
    else if (strobe.lineCount && lineCnt != LINE_TOP) lineCnt <= lineCnt + 1'b1;
  end

  // VBUS-valid width counter, saturating at its limit.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                    vbusCnt <= '0;
    else if (strobe.vbusFlush)                    vbusCnt <= '0;
    else if (strobe.vbusCount && vbusCnt != VBUS_TOP) vbusCnt <= vbusCnt + 1'b1;
  end

  // Sticky flag: a set wins over a clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 reqDetected <= 1'b0;
    else if (strobe.setFlag)   reqDetected <= 1'b1;
    else if (strobe.clearFlag) reqDetected <= 1'b0;
  end

  always_comb begin
    status.lineHigh   = syncOut[0] | syncOut[1];
    status.lineAtLast = (lineCnt == LINE_LAST);
    status.vbusHigh   = syncOut[2];
    status.vbusRise   = syncOut[2] & ~vbusPrev;
    status.vbusAtLast = (vbusCnt == VBUS_LAST);
  end

endmodule

// File: rtl/srqd_ctrl.sv
module srqd_ctrl
  import srqd_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         msTick,
  input  logic         detEnable,
  input  logic         detSelLine,
  input  logic         aDrivesVbus,
  input  logic         clearReq,
  input  srqd_status_t status,
  output srqd_strobe_t strobe
);

  logic enPrev;
  logic selPrev;
  logic vbusArmed;
  logic modeChange;
  logic lineActive;
  logic vbusActive;
  logic vbusKeep;
  logic vbusRun;
  logic lineRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev  <= 1'b0;
      selPrev <= 1'b0;
    end else begin
      enPrev  <= detEnable;
      selPrev <= detSelLine;
    end
  end

  always_comb begin
    modeChange = (detEnable != enPrev) || (detSelLine != selPrev);
    lineActive = detEnable & detSelLine & ~modeChange;
    vbusActive = detEnable & ~detSelLine & ~modeChange;
    lineRun    = lineActive & status.lineHigh;
    vbusKeep   = vbusActive & status.vbusHigh & ~aDrivesVbus;
    vbusRun    = vbusKeep & vbusArmed;
  end

  // Arm on a VBUS rise the A-device did not cause; disarm when the conditions drop.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          vbusArmed <= 1'b0;
    else if (!vbusKeep) vbusArmed <= 1'b0;
    else if (status.vbusRise) vbusArmed <= 1'b1;
  end

  always_comb begin
    strobe.lineFlush = ~lineRun;
    strobe.lineCount = lineRun & msTick;
    strobe.vbusFlush = ~vbusRun;
    strobe.vbusCount = vbusRun & msTick;
    strobe.setFlag   = (strobe.lineCount & status.lineAtLast)
                     | (strobe.vbusCount & status.vbusAtLast);
    strobe.clearFlag = clearReq;
  end

endmodule

// File: rtl/otg_sreq_detect.sv
module otg_sreq_detect
  import srqd_pkg::*;
#(
  parameter int LINE_MIN_TICKS = 5,
  parameter int VBUS_MIN_TICKS = 1,
  parameter int SYNC_DEPTH     = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic msTick,
  input  logic detEnable,
  input  logic detSelLine,
  input  logic aDrivesVbus,
  input  logic dpRaw,
  input  logic dmRaw,
  input  logic vbusRaw,
  input  logic clearReq,
  output logic reqDetected
);

  localparam int MAX_TICKS = (LINE_MIN_TICKS > VBUS_MIN_TICKS) ? LINE_MIN_TICKS : VBUS_MIN_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  srqd_strobe_t     strobe;
  srqd_status_t     status;
  logic [CNT_W-1:0] lineCnt;
  logic [CNT_W-1:0] vbusCnt;

  srqd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .msTick(msTick), .detEnable(detEnable),
    .detSelLine(detSelLine), .aDrivesVbus(aDrivesVbus), .clearReq(clearReq),
    .status(status), .strobe(strobe)
  );

  srqd_dpath #(
    .LINE_MIN_TICKS(LINE_MIN_TICKS), .VBUS_MIN_TICKS(VBUS_MIN_TICKS),
    .SYNC_DEPTH(SYNC_DEPTH), .CNT_W(CNT_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .dpRaw(dpRaw), .dmRaw(dmRaw), .vbusRaw(vbusRaw),
    .strobe(strobe), .status(status), .lineCnt(lineCnt), .vbusCnt(vbusCnt),
    .reqDetected(reqDetected)
  );

endmodule

// File: rtl/srqd_checker.sv
module srqd_checker #(
  parameter int LINE_MIN_TICKS = 5,
  parameter int CNT_W          = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             detEnable,
  input logic             detSelLine,
  input logic             clearReq,
  input logic [CNT_W-1:0] lineCnt,
  input logic [CNT_W-1:0] vbusCnt,
  input logic             reqDetected
);

  a_r1_reset_clear: assert property (@(posedge clk) !rstN |=> !reqDetected);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (reqDetected && !clearReq) |=> reqDetected);

  a_r6_no_rise_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (!detEnable && !reqDetected) |=> !reqDetected);

  a_r8_flush_on_change: assert property (@(posedge clk) disable iff (!rstN)
    ((detSelLine != $past(detSelLine)) || (detEnable != $past(detEnable)))
      |=> (lineCnt == '0 && vbusCnt == '0));

  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    lineCnt <= CNT_W'(LINE_MIN_TICKS));

endmodule

bind otg_sreq_detect srqd_checker #(
  .LINE_MIN_TICKS(LINE_MIN_TICKS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .detEnable(detEnable), .detSelLine(detSelLine),
  .clearReq(clearReq), .lineCnt(lineCnt), .vbusCnt(vbusCnt),
  .reqDetected(reqDetected)
);

// File: tb/sim_otg_sreq_detect.sv
module sim_otg_sreq_detect;

  localparam int LMIN = 5;
  localparam int VMIN = 1;
  localparam int TICK_PERIOD = 4;

  logic clk = 0, rstN = 0, msTick = 0, detEnable = 0, detSelLine = 0;
  logic aDrivesVbus = 0, dpRaw = 0, dmRaw = 0, vbusRaw = 0, clearReq = 0;
  logic reqDetected;

  int compared = 0, mismatched = 0, tickPh = 0;
  bit finished = 0;
  string curTag = "R1";

  // Behavioural reference state.
  int dpQ[$], dmQ[$], vbQ[$];
  int mEnQ = 0, mSelQ = 0, mVbPrev = 0, mArm = 0, mLc = 0, mVc = 0, mFlag = 0;

  always #2 clk = ~clk;

  otg_sreq_detect u0 (
    .clk(clk), .rstN(rstN), .msTick(msTick), .detEnable(detEnable),
    .detSelLine(detSelLine), .aDrivesVbus(aDrivesVbus), .dpRaw(dpRaw),
    .dmRaw(dmRaw), .vbusRaw(vbusRaw), .clearReq(clearReq),
    .reqDetected(reqDetected)
  );

  task automatic compare(input int expv, input string tag);
    compared++;
    if (reqDetected !== expv[0]) begin
      mismatched++;
      $display("FAIL %s: reqDetected=%b expected=%0d at %0t", tag, reqDetected, expv, $time);
    end
  endtask

  task automatic modelReset();
    dpQ = '{0, 0}; dmQ = '{0, 0}; vbQ = '{0, 0};
    mEnQ = 0; mSelQ = 0; mVbPrev = 0; mArm = 0; mLc = 0; mVc = 0; mFlag = 0;
  endtask

  // One clock: compute the expected next state, take the edge, then compare at the falling edge.
  task automatic step();
    int dpS, dmS, vbS, chg, lineOn, vbOn, hi, nLc, setL, rise, keep, nArm, run, nVc, setV, nFlag;
    msTick = ((tickPh % TICK_PERIOD) == TICK_PERIOD - 1);
    tickPh++;
    dpS = dpQ[0]; dmS = dmQ[0]; vbS = vbQ[0];
    chg = (detEnable != mEnQ[0]) || (detSelLine != mSelQ[0]);
    lineOn = detEnable && detSelLine && !chg;
    vbOn = detEnable && !detSelLine && !chg;
    hi = dpS || dmS;
    nLc = (!lineOn || !hi) ? 0 : ((msTick && mLc < LMIN) ? mLc + 1 : mLc);
    setL = lineOn && hi && msTick && (mLc == LMIN - 1);
    rise = vbS && !mVbPrev;
    keep = vbOn && vbS && !aDrivesVbus;
    nArm = !keep ? 0 : (rise ? 1 : mArm);
    run = keep && mArm;
    nVc = !run ? 0 : ((msTick && mVc < VMIN) ? mVc + 1 : mVc);
    setV = run && msTick && (mVc == VMIN - 1);
    nFlag = (setL || setV) ? 1 : (clearReq ? 0 : mFlag);
    @(posedge clk);
    mEnQ = detEnable; mSelQ = detSelLine; mVbPrev = vbS;
    mLc = nLc; mArm = nArm; mVc = nVc; mFlag = nFlag;
    void'(dpQ.pop_front()); dpQ.push_back(dpRaw);
    void'(dmQ.pop_front()); dmQ.push_back(dmRaw);
    void'(vbQ.pop_front()); vbQ.push_back(vbusRaw);
    @(negedge clk);
    compare(mFlag, curTag);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic clearFlag();
    clearReq = 1; run(1); clearReq = 0; run(2);
  endtask

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    curTag = "R1";
    compare(0, "R1");
    detEnable = 1; detSelLine = 1;
    rstN = 1;
    run(3);
    compare(0, "R1");

    curTag = "R2";  // DP held for six ticks in line mode
    dpRaw = 1; run(6 * TICK_PERIOD); dpRaw = 0; run(8);
    compare(1, "R2");
    curTag = "R7"; clearFlag(); compare(0, "R7");

    curTag = "R3";  // four ticks at most: too short
    dpRaw = 1; run(3 * TICK_PERIOD + 2); dpRaw = 0; run(8);
    compare(0, "R3");

    curTag = "R2";  // DM alone
    dmRaw = 1; run(7 * TICK_PERIOD); dmRaw = 0; run(8);
    compare(1, "R2");
    clearFlag();

    curTag = "R4";  // line pulse while VBUS mode is selected
    detSelLine = 0; run(4);
    dpRaw = 1; run(7 * TICK_PERIOD); dpRaw = 0; run(8);
    compare(0, "R4");
    detSelLine = 1; run(4);  // VBUS pulse while line mode is selected
    vbusRaw = 1; run(4 * TICK_PERIOD); vbusRaw = 0; run(8);
    compare(0, "R4");

    curTag = "R5";
    detSelLine = 0; run(4);
    vbusRaw = 1; run(3 * TICK_PERIOD); vbusRaw = 0; run(8);
    compare(1, "R5");
    clearFlag();
    aDrivesVbus = 1; vbusRaw = 1; run(4 * TICK_PERIOD);
    vbusRaw = 0; run(4); aDrivesVbus = 0; run(8);
    compare(0, "R5");

    curTag = "R6";
    detEnable = 0; detSelLine = 1; run(4);
    dpRaw = 1; run(7 * TICK_PERIOD); dpRaw = 0; run(4);
    detSelLine = 0; vbusRaw = 1; run(4 * TICK_PERIOD); vbusRaw = 0; run(8);
    compare(0, "R6");
    detEnable = 1;

    curTag = "R8";  // 3 ticks, mode toggle, 3 ticks: not enough; 3 more: enough
    detSelLine = 1; run(4);
    dpRaw = 1; run(3 * TICK_PERIOD);
    detSelLine = 0; run(1); detSelLine = 1;
    run(3 * TICK_PERIOD);
    compare(0, "R8");
    run(3 * TICK_PERIOD);
    compare(1, "R8");
    dpRaw = 0; run(4);
    clearFlag();

    curTag = "R7";  // clear held high across a detection: set wins for one cycle
    clearReq = 1; dpRaw = 1; run(7 * TICK_PERIOD);
    dpRaw = 0; clearReq = 0; run(8);
    compare(0, "R7");

    curTag = "R9";  // exact two-cycle latency, followed cycle by cycle
    tickPh = 0;
    dpRaw = 1; run(5 * TICK_PERIOD + 1); dpRaw = 0; run(8);
    compare(1, "R9");
    clearFlag();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule